// File: doc/BRIEF.md
# Watch Stepper Bridge Drive with Stop and Test Pad

This block generates the coil drive for a two-phase watch stepper motor through four bridge switches: a high-side and a low-side switch on each coil terminal. In normal running it produces one short drive pulse per second, and the current direction through the coil reverses on every pulse. The on-time of each pulse is set by a width input counted in clock cycles. A duty-level code goes out next to the switch enables for the pulse shaper that follows.

A single three-state control pad overrides the normal running. Its two level detectors arrive as separate inputs. When the pad is tied high, the drive halts and every switch opens. When it is tied low, the motor is stepped at the 32 Hz tick rate so that the mechanism can be exercised quickly. When the pad is left floating again, the drive waits exactly one second. It then resumes with a pulse at the lowest duty level, in the direction opposite to the last pulse it issued. A pad level takes effect only after two successive 32 Hz samples agree, which gives a debounce time of 31 ms to 62 ms.

Top module: `step_drive_ctrl`

## Requirements
- R1: After reset all four switches are open and no pulse is issued before the first 1 Hz tick.
- R2: A pad level is accepted only on a 32 Hz tick whose sample equals the previous 32 Hz sample. A level seen at a single sample is ignored. When both detectors are active, high wins.
- R3: In run mode each 1 Hz tick starts one pulse in the next clock cycle. The pulse lasts `pulse_width` cycles, and successive pulses alternate in direction.
- R4: A positive pulse closes `sw_hi_a` and `sw_lo_b`, and a negative pulse closes `sw_hi_b` and `sw_lo_a`. The two switches on one terminal are never closed together, and all four are open between pulses.
- R5: Once pad-high is accepted, all switches are open from the following cycle, cutting short any pulse in progress, and 1 Hz ticks are ignored.
- R6: While pad-low is accepted, every 32 Hz tick starts a pulse, with direction alternating.
- R7: After the pad is released and the release is accepted, the first pulse starts on the 32nd 32 Hz tick that follows. Any 1 Hz tick before then is ignored.
- R8: The first pulse after a release has the opposite direction to the last pulse issued before it, including a pulse that was cut short.
- R9: `duty_level` is 0 from an accepted release until the next pulse started by a 1 Hz tick, or until test mode is entered. At all other times it equals `duty_cfg`.
- R10: The direction memory is cleared only by reset, and the first pulse after reset is positive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32hz | input | 1 | One-cycle strobe at 32 Hz |
| tick_1hz | input | 1 | One-cycle strobe at 1 Hz, coincident with a 32 Hz strobe |
| pad_high | input | 1 | Pad detected tied high (asynchronous) |
| pad_low | input | 1 | Pad detected tied low (asynchronous) |
| pulse_width | input | PW_W | Pulse on-time in clock cycles; 0 issues no pulse |
| duty_cfg | input | DUTY_W | Configured duty level |
| sw_hi_a | output | 1 | High-side switch, terminal A |
| sw_lo_a | output | 1 | Low-side switch, terminal A |
| sw_hi_b | output | 1 | High-side switch, terminal B |
| sw_lo_b | output | 1 | Low-side switch, terminal B |
| duty_level | output | DUTY_W | Duty level applied to the current pulse |

## Verification
The bench logs every pulse with its start tick, direction, length and duty level, then compares the log with tick numbers it works out from the pad timing. It targets five corner cases:
- A one-sample pad glitch: a filter with no agreement check would halt the drive.
- The restart delay, where an off-by-one counter would fire on the 31st or 33rd tick, or would obey a 1 Hz tick during the wait.
- A stop accepted on the very tick that starts a pulse: a design that aborts from its mode register instead of the accepted request would leave the coil driven for two cycles.
- A restart after test mode or after a cut pulse, which catches a direction memory that is reset or that fails to record the cut pulse.
- The duty level through release and re-entry, which catches a level that is zeroed late or not restored.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    PAD_RUN  = 2'd0,
    PAD_STOP = 2'd1,
    PAD_TEST = 2'd2
  } pad_req_t;

  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_STOP = 2'd1,
    M_TEST = 2'd2,
    M_WAIT = 2'd3
  } drv_mode_t;
endpackage

// File: rtl/sdc_pad_filter.sv
module sdc_pad_filter
  import sdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     pad_high,
  input  logic     pad_low,
  output pad_req_t req
);
  logic [SYNC_STAGES-1:0] hi_sync_q, lo_sync_q;
  pad_req_t sample;
  pad_req_t last_q, last_d;
  pad_req_t req_q, req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_sync_q <= '0;
      lo_sync_q <= '0;
    end else begin
      hi_sync_q <= {hi_sync_q[SYNC_STAGES-2:0], pad_high};
      lo_sync_q <= {lo_sync_q[SYNC_STAGES-2:0], pad_low};
    end
  end

  always_comb begin
    if (hi_sync_q[SYNC_STAGES-1])      sample = PAD_STOP;
    else if (lo_sync_q[SYNC_STAGES-1]) sample = PAD_TEST;
    else                               sample = PAD_RUN;
    last_d = last_q;
    req_d  = req_q;
    if (tick) begin
      last_d = sample;
      if (sample == last_q) req_d = sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= PAD_RUN;
      req_q  <= PAD_RUN;
    end else begin
      last_q <= last_d;
      req_q  <= req_d;
    end
  end

  assign req = req_q;

  // R2
  req_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(req_q));
endmodule

// File: rtl/sdc_mode_ctrl.sv
module sdc_mode_ctrl
  import sdc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32,
  localparam int WAIT_W = $clog2(TICKS_PER_SEC)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_32hz,
  input  logic     tick_1hz,
  input  pad_req_t req,
  output logic     fire,
  output logic     low_duty
);
  localparam logic [WAIT_W-1:0] LAST_TICK = WAIT_W'(TICKS_PER_SEC - 1);

  drv_mode_t mode_q, mode_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic low_q, low_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = '0;
    fire   = 1'b0;
    unique case (mode_q)
      M_RUN: begin
        fire = tick_1hz;
        if (req == PAD_STOP)      mode_d = M_STOP;
        else if (req == PAD_TEST) mode_d = M_TEST;
      end
      M_STOP: begin
        if (req == PAD_TEST)     mode_d = M_TEST;
        else if (req == PAD_RUN) mode_d = M_WAIT;
      end
      M_TEST: begin
        fire = tick_32hz;
        if (req == PAD_STOP)     mode_d = M_STOP;
        else if (req == PAD_RUN) mode_d = M_WAIT;
      end
      M_WAIT: begin
        cnt_d = cnt_q;
        if (req == PAD_STOP)      mode_d = M_STOP;
        else if (req == PAD_TEST) mode_d = M_TEST;
        else if (tick_32hz) begin
          if (cnt_q == LAST_TICK) begin
            fire   = 1'b1;
            mode_d = M_RUN;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: mode_d = M_RUN;
    endcase

    low_d = low_q;
    if (mode_d == M_WAIT && mode_q != M_WAIT) low_d = 1'b1;
    else if (mode_d == M_TEST)                low_d = 1'b0;
    else if (fire && mode_q == M_RUN)         low_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_RUN;
      cnt_q  <= '0;
      low_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      low_q  <= low_d;
    end
  end

  assign low_duty = low_q;

  // R9
  wait_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WAIT) |-> low_q);

  // R7
  wait_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WAIT && fire) |=> (mode_q == M_RUN));
endmodule

// File: rtl/sdc_pulse_gen.sv
module sdc_pulse_gen #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            abort,
  input  logic [PW_W-1:0] width,
  output logic            active,
  output logic            positive
);
  logic [PW_W-1:0] on_q, on_d;
  logic pol_q, pol_d;
  logic start;

  always_comb begin
    start = fire && (on_q == '0) && (width != '0) && !abort;
    pol_d = pol_q;
    if (abort)            on_d = '0;
    else if (start)       on_d = width;
    else if (on_q != '0)  on_d = on_q - 1'b1;
    else                  on_d = '0;
    if (start) pol_d = ~pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= '0;
      pol_q <= 1'b0;
    end else begin
      on_q  <= on_d;
      pol_q <= pol_d;
    end
  end

  assign active   = (on_q != '0);
  assign positive = pol_q;

  // R3
  dir_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && $past(rst_n) && fire && width != '0 && !abort) |=> (active && positive != $past(positive)));
endmodule

// File: rtl/step_drive_ctrl.sv
module step_drive_ctrl
  import sdc_pkg::*;
#(
  parameter int PW_W          = 8,
  parameter int DUTY_W        = 3,
  parameter int TICKS_PER_SEC = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32hz,
  input  logic              tick_1hz,
  input  logic              pad_high,
  input  logic              pad_low,
  input  logic [PW_W-1:0]   pulse_width,
  input  logic [DUTY_W-1:0] duty_cfg,
  output logic              sw_hi_a,
  output logic              sw_lo_a,
  output logic              sw_hi_b,
  output logic              sw_lo_b,
  output logic [DUTY_W-1:0] duty_level
);
  pad_req_t req;
  logic fire, low_duty, active, positive;

  sdc_pad_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk(clk), .rst_n(rst_n), .tick(tick_32hz),
    .pad_high(pad_high), .pad_low(pad_low), .req(req)
  );

  sdc_mode_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_mode (
    .clk(clk), .rst_n(rst_n), .tick_32hz(tick_32hz), .tick_1hz(tick_1hz),
    .req(req), .fire(fire), .low_duty(low_duty)
  );

  sdc_pulse_gen #(.PW_W(PW_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .abort(req == PAD_STOP),
    .width(pulse_width), .active(active), .positive(positive)
  );

  assign sw_hi_a    = active &&  positive;
  assign sw_lo_b    = active &&  positive;
  assign sw_hi_b    = active && !positive;
  assign sw_lo_a    = active && !positive;
  assign duty_level = low_duty ? '0 : duty_cfg;

  // R4
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((sw_hi_a && sw_lo_a) || (sw_hi_b && sw_lo_b)));

  // R5
  stop_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == PAD_STOP) |=> !(sw_hi_a || sw_lo_a || sw_hi_b || sw_lo_b));
endmodule

// File: tb/tb_step_drive_ctrl.sv
module tb_step_drive_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CYC_PER_TICK = 8;
  localparam int PW = 3;
  localparam int DUTY = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32hz = 1'b0, tick_1hz = 1'b0;
  logic pad_high = 1'b0, pad_low = 1'b0;
  logic [7:0] pulse_width = 8'(PW);
  logic [2:0] duty_cfg = 3'(DUTY);
  logic sw_hi_a, sw_lo_a, sw_hi_b, sw_lo_b;
  logic [2:0] duty_level;

  int checks = 0, errors = 0;
  int cyc = 0, tk = 0;
  int p_tick[64];
  int p_len[64];
  int p_duty[64];
  bit p_pol[64];
  int np = 0;
  int bad_pat = 0;
  bit was_on = 1'b0;
  bit done = 1'b0;

  step_drive_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick_32hz(tick_32hz), .tick_1hz(tick_1hz),
    .pad_high(pad_high), .pad_low(pad_low), .pulse_width(pulse_width),
    .duty_cfg(duty_cfg), .sw_hi_a(sw_hi_a), .sw_lo_a(sw_lo_a),
    .sw_hi_b(sw_hi_b), .sw_lo_b(sw_lo_b), .duty_level(duty_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // pulse logger first, then tick generation, in one process
  always @(negedge clk) begin
    bit on;
    on = sw_hi_a | sw_lo_a | sw_hi_b | sw_lo_b;
    if (on) begin
      if (!((sw_hi_a && sw_lo_b && !sw_hi_b && !sw_lo_a) ||
            (sw_hi_b && sw_lo_a && !sw_hi_a && !sw_lo_b)))
        bad_pat++;
      if (!was_on && np < 64) begin
        p_tick[np] = tk;
        p_pol[np]  = sw_hi_a;
        p_duty[np] = int'(duty_level);
        p_len[np]  = 1;
        np++;
      end else if (was_on && np > 0) begin
        p_len[np-1]++;
      end
    end
    was_on = on;
    cyc++;
    if (cyc % CYC_PER_TICK == 0) begin
      tk++;
      tick_32hz = 1'b1;
      tick_1hz  = (tk % 32 == 0);
    end else begin
      tick_32hz = 1'b0;
      tick_1hz  = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic at_tick(input int t);
    while (tk < t) @(posedge clk);
    #1;
  endtask

  task automatic chk_pulse(input int idx, input string req, input int t, input bit pol, input int duty);
    chk(np > idx, req, np, idx + 1);
    if (np > idx) begin
      chk(p_tick[idx] == t, req, p_tick[idx], t);
      chk(p_pol[idx] == pol, req, int'(p_pol[idx]), int'(pol));
      chk(p_duty[idx] == duty, req, p_duty[idx], duty);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(!(sw_hi_a | sw_lo_a | sw_hi_b | sw_lo_b), "R1", 1, 0);
    // R9: outside a release window the duty follows the configuration
    chk(duty_level == 3'(DUTY), "R9", int'(duty_level), DUTY);
    rst_n = 1'b1;

    // R1/R3/R10: normal pulses, first one positive
    at_tick(31);
    chk(np == 0, "R1", np, 0);
    at_tick(100);
    chk(np == 3, "R3", np, 3);
    chk_pulse(0, "R10", 32, 1'b1, DUTY);
    chk_pulse(1, "R3", 64, 1'b0, DUTY);
    chk_pulse(2, "R3", 96, 1'b1, DUTY);
    for (int i = 0; i < 3; i++) chk(p_len[i] == PW, "R3", p_len[i], PW);

    // R2: one-sample glitch must be ignored
    at_tick(104); pad_high = 1'b1;
    at_tick(105); pad_high = 1'b0;
    at_tick(130);
    chk_pulse(3, "R2", 128, 1'b0, DUTY);

    // R5: stop held across two 1 Hz ticks
    pad_high = 1'b1;
    at_tick(200);
    chk(np == 4, "R5", np, 4);
    chk(!(sw_hi_a | sw_lo_a | sw_hi_b | sw_lo_b), "R5", 1, 0);

    // R7/R8/R9: release accepted at 202, first pulse at 234
    pad_high = 1'b0;
    at_tick(233);
    chk(np == 4, "R7", np, 4);
    chk(duty_level == 3'd0, "R9", int'(duty_level), 0);
    at_tick(240);
    chk_pulse(4, "R7", 234, 1'b1, 0);
    chk(np == 5, "R7", np, 5);
    at_tick(258);
    chk_pulse(5, "R9", 256, 1'b0, DUTY);

    // R6: test mode accepted at 262, released after 275 (accepted 277)
    at_tick(260); pad_low = 1'b1;
    at_tick(275); pad_low = 1'b0;
    at_tick(300);
    chk(np == 21, "R6", np, 21);
    for (int i = 0; i < 15; i++) begin
      if (np > 6 + i) begin
        chk(p_tick[6+i] == 263 + i, "R6", p_tick[6+i], 263 + i);
        chk(p_pol[6+i] == (i % 2 == 0), "R6", int'(p_pol[6+i]), int'(i % 2 == 0));
      end
    end

    // R8: restart after test mode reverses the last test pulse
    at_tick(315);
    chk_pulse(21, "R8", 309, 1'b0, 0);
    at_tick(322);
    chk_pulse(22, "R3", 320, 1'b1, DUTY);

    // R5: stop accepted on the tick that starts a pulse cuts it to one cycle
    at_tick(350); pad_high = 1'b1;
    at_tick(360);
    chk_pulse(23, "R5", 352, 1'b0, DUTY);
    if (np > 23) chk(p_len[23] == 1, "R5", p_len[23], 1);
    pad_high = 1'b0;

    // R8: the cut pulse still counts as the last direction
    at_tick(398);
    chk_pulse(24, "R8", 394, 1'b1, 0);
    chk(np == 25, "R7", np, 25);

    // R4: switch patterns seen throughout
    chk(bad_pat == 0, "R4", bad_pat, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", tk, 398);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule